// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block is a watchdog counter that advances on a slow oscillator tick, given to it as a one-cycle enable in the system clock domain. Software must clear it in time with a clear strobe. If software does not, the counter reaches the limit picked by a 2-bit period code. The block then issues a one-cycle request for a full device reset and starts counting again from zero.

The four limits are uneven powers of two: 8192, 16384, 65536 and 262144 ticks with the default parameters. Power-on reset and the clear strobe are the only things that zero the count. Warm resets and wakeups leave it untouched, so the first timeout after such an event can come early. A watchdog enable gates counting. While it is low, the counter is held at zero. The count is brought out for debug.

Top module: `slowtick_watchdog`

## Requirements
- R1: While power-on reset (`por_n` low) is asserted and in the first cycle after it is released, `count_dbg` is 0 and `rst_req` is 0.
- R2: With `wd_en` high and `kick` low, each clock cycle with `tick_en` high adds one to `count_dbg`, and a cycle with `tick_en` low leaves it unchanged.
- R3: A tick that arrives while the count equals the selected limit minus one sets the count to 0 and drives `rst_req` high in the next cycle.
- R4: Period code `period_sel` 2'b00, 2'b01, 2'b10 and 2'b11 selects limits of 2^TAP0, 2^TAP1, 2^TAP2 and 2^TAP3 ticks. The defaults are 8192, 16384, 65536 and 262144.
- R5: `rst_req` is high for exactly one clock cycle per timeout.
- R6: `kick` high sets the count to 0 in the next cycle at any count, takes priority over a tick in the same cycle, and raises no request.
- R7: While `wd_en` is low, the count goes to 0 and stays there, and no request is raised, whatever `tick_en` does.
- R8: A change of `period_sel` applies from the very next tick against the current count. If the count already equals or exceeds the new limit minus one, that tick causes a timeout.
- R9: After a timeout the count restarts from 0, so the next timeout needs a full period of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_en | input | 1 | One-cycle pulse per slow-oscillator tick |
| kick | input | 1 | Software clear strobe |
| wd_en | input | 1 | Watchdog enable; low holds the count at zero |
| period_sel | input | 2 | Timeout period code |
| rst_req | output | 1 | One-cycle device reset request |
| count_dbg | output | CNT_W | Current count, for debug |

## Verification
Each result is one register away from its cause. A tick, kick, disable or period change shows up in `count_dbg` and `rst_req` at the first rising edge after it is applied, and `rst_req` drops again one edge later. The bench changes inputs on the falling edge and samples on the next falling edge, so every check sees exactly one edge of effect. It then holds the inputs idle for one more sampled cycle to confirm that the request pulse has ended. The bench shrinks the tap parameters to keep full-period runs short, while the code-to-limit mapping stays the same.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int WDT_NUM_PERIODS = 4;
   typedef logic [1:0] wdt_sel_t;
endpackage

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel #(
   parameter int CNT_W = 18,
   parameter int TAP0  = 13,
   parameter int TAP1  = 14,
   parameter int TAP2  = 16,
   parameter int TAP3  = 18
) (
   input  wdt_pkg::wdt_sel_t   sel,
   output logic [CNT_W-1:0]    limit_m1
);
   localparam int NP = wdt_pkg::WDT_NUM_PERIODS;
   localparam int TAPS [NP] = '{TAP0, TAP1, TAP2, TAP3};

   logic [CNT_W-1:0] table_m1 [NP];

   for (genvar i = 0; i < NP; i++) begin : g_tap
      if (TAPS[i] == CNT_W) begin : g_full
         assign table_m1[i] = {CNT_W{1'b1}};
      end else begin : g_part
         assign table_m1[i] = CNT_W'((64'd1 << TAPS[i]) - 64'd1);
      end
   end

   assign limit_m1 = table_m1[sel];
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick_en,
   input  logic             kick,
   input  logic             wd_en,
   input  logic [CNT_W-1:0] limit_m1,
   output logic             expire,
   output logic [CNT_W-1:0] count
);
   logic live_tick;
   logic [CNT_W-1:0] count_nxt;

   assign live_tick = wd_en && !kick && tick_en;
   assign expire    = live_tick && (count >= limit_m1);

   always_comb begin
      count_nxt = count;
      if (!wd_en || kick) begin
         count_nxt = '0;
      end else if (tick_en) begin
         count_nxt = expire ? '0 : count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) count <= '0;
      else        count <= count_nxt;
   end
endmodule

// File: rtl/wdt_req_pulse.sv
module wdt_req_pulse (
   input  logic clk,
   input  logic por_n,
   input  logic expire,
   output logic rst_req
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) rst_req <= 1'b0;
      else        rst_req <= expire;
   end
endmodule

// File: rtl/slowtick_watchdog.sv
module slowtick_watchdog #(
   parameter int CNT_W = 18,
   parameter int TAP0  = 13,
   parameter int TAP1  = 14,
   parameter int TAP2  = 16,
   parameter int TAP3  = 18
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick_en,
   input  logic             kick,
   input  logic             wd_en,
   input  logic [1:0]       period_sel,
   output logic             rst_req,
   output logic [CNT_W-1:0] count_dbg
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("slowtick_watchdog: CNT_W must be 2..32");
   end
   if (!(TAP0 >= 1 && TAP0 < TAP1 && TAP1 < TAP2 && TAP2 < TAP3 && TAP3 <= CNT_W)) begin : g_bad_taps
      $error("slowtick_watchdog: taps must rise strictly and fit CNT_W");
   end

   logic [CNT_W-1:0] limit_m1;
   logic             expire;

   wdt_limit_sel #(
      .CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
   ) u_limit (
      .sel      (period_sel),
      .limit_m1 (limit_m1)
   );

   wdt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .por_n    (por_n),
      .tick_en  (tick_en),
      .kick     (kick),
      .wd_en    (wd_en),
      .limit_m1 (limit_m1),
      .expire   (expire),
      .count    (count_dbg)
   );

   wdt_req_pulse u_req (
      .clk     (clk),
      .por_n   (por_n),
      .expire  (expire),
      .rst_req (rst_req)
   );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
   parameter int CNT_W = 18,
   parameter int TAP0  = 13,
   parameter int TAP1  = 14,
   parameter int TAP2  = 16,
   parameter int TAP3  = 18
) (
   input logic             clk,
   input logic             por_n,
   input logic             tick_en,
   input logic             kick,
   input logic             wd_en,
   input logic [1:0]       period_sel,
   input logic             rst_req,
   input logic [CNT_W-1:0] count_dbg
);
   logic [63:0] lim;
   always_comb begin
      case (period_sel)
         2'd0:    lim = 64'd1 << TAP0;
         2'd1:    lim = 64'd1 << TAP1;
         2'd2:    lim = 64'd1 << TAP2;
         default: lim = 64'd1 << TAP3;
      endcase
   end

   logic run_tick;
   assign run_tick = wd_en && !kick && tick_en;

   // R2
   p_advance_r2: assert property (@(posedge clk) disable iff (!por_n)
      (run_tick && (64'(count_dbg) + 64'd1 < lim)) |=> (count_dbg == $past(count_dbg) + 1'b1));
   p_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
      (wd_en && !kick && !tick_en) |=> ($stable(count_dbg) && !rst_req));
   // R3, R8
   p_expire_r3: assert property (@(posedge clk) disable iff (!por_n)
      (run_tick && (64'(count_dbg) + 64'd1 >= lim)) |=> (rst_req && count_dbg == '0));
   // R5
   p_one_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |=> !rst_req);
   // R6
   p_kick_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
      kick |=> (count_dbg == '0 && !rst_req));
   // R7
   p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!por_n)
      !wd_en |=> (count_dbg == '0 && !rst_req));
   // R9
   p_restart_r9: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |-> (count_dbg == '0));
endmodule

bind slowtick_watchdog wdt_chk #(
   .CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .tick_en    (tick_en),
   .kick       (kick),
   .wd_en      (wd_en),
   .period_sel (period_sel),
   .rst_req    (rst_req),
   .count_dbg  (count_dbg)
);

// File: tb/sim_slowtick_watchdog.sv
`timescale 1ns/1ps
module sim_slowtick_watchdog;
   localparam int W = 8;
   localparam int T0 = 3, T1 = 4, T2 = 6, T3 = 8;
   localparam int TAPS [4] = '{T0, T1, T2, T3};

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic tick_en = 1'b0, kick = 1'b0, wd_en = 1'b0;
   logic [1:0] period_sel = 2'd0;
   logic rst_req;
   logic [W-1:0] count_dbg;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   slowtick_watchdog #(.CNT_W(W), .TAP0(T0), .TAP1(T1), .TAP2(T2), .TAP3(T3)) u0 (
      .clk(clk), .por_n(por_n), .tick_en(tick_en), .kick(kick), .wd_en(wd_en),
      .period_sel(period_sel), .rst_req(rst_req), .count_dbg(count_dbg)
   );

   // {tick, kick, en, sel[1:0], exp_count[7:0], exp_req}
   localparam int NV = 15;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1,1'b0,1'b1,2'd0,8'd1,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd2,1'b0},
      {1'b0,1'b0,1'b1,2'd0,8'd2,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd3,1'b0},
      {1'b1,1'b1,1'b1,2'd0,8'd0,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd1,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd2,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd3,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd4,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd5,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd6,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd7,1'b0},
      {1'b1,1'b0,1'b1,2'd0,8'd0,1'b1},
      {1'b0,1'b0,1'b1,2'd0,8'd0,1'b0},
      {1'b1,1'b0,1'b0,2'd0,8'd0,1'b0}
   };

   task automatic check(input logic [W-1:0] ec, input logic er, input string tag);
      tests++;
      if (count_dbg !== ec || rst_req !== er) begin
         fails++;
         $display("FAIL %s: count=%0d req=%0b expected count=%0d req=%0b",
                  tag, count_dbg, rst_req, ec, er);
      end
   endtask

   // apply inputs after a falling edge; results are sampled at the next falling edge
   task automatic step(input logic t, input logic k, input logic e, input logic [1:0] s);
      tick_en = t; kick = k; wd_en = e; period_sel = s;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(8'd0, 1'b0, "R1 in reset");
      por_n = 1'b1;
      @(negedge clk);
      check(8'd0, 1'b0, "R1 after release");

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:9]);
         check(VEC[i][8:1], VEC[i][0], $sformatf("R2/R3/R6/R7 vector %0d", i));
      end

      // R4, R5, R9: every period code, full length, twice in a row
      for (int s = 0; s < 4; s++) begin
         int lim;
         lim = 1 << TAPS[s];
         step(1'b0, 1'b1, 1'b1, 2'(s));
         check(8'd0, 1'b0, "R6 kick before period run");
         for (int rep = 0; rep < 2; rep++) begin
            for (int n = 0; n < lim - 1; n++) step(1'b1, 1'b0, 1'b1, 2'(s));
            check(W'(lim - 1), 1'b0, $sformatf("R4 code %0d one short of limit", s));
            step(1'b1, 1'b0, 1'b1, 2'(s));
            check(8'd0, 1'b1, $sformatf("R4 code %0d timeout, pass %0d (R9)", s, rep));
            step(1'b0, 1'b0, 1'b1, 2'(s));
            check(8'd0, 1'b0, "R5 request lasts one cycle");
         end
      end

      // R8: shrink the period below the current count
      for (int n = 0; n < 10; n++) step(1'b1, 1'b0, 1'b1, 2'd1);
      check(8'd10, 1'b0, "R8 count 10 on code 01");
      step(1'b0, 1'b0, 1'b1, 2'd0);
      check(8'd10, 1'b0, "R8 code change alone does not expire");
      step(1'b1, 1'b0, 1'b1, 2'd0);
      check(8'd0, 1'b1, "R8 past-limit count expires on next tick");
      step(1'b0, 1'b0, 1'b1, 2'd0);
      check(8'd0, 1'b0, "R5 pulse ends");

      // R8: widen the period just before the old limit
      for (int n = 0; n < 7; n++) step(1'b1, 1'b0, 1'b1, 2'd0);
      check(8'd7, 1'b0, "R8 at old limit minus one");
      step(1'b1, 1'b0, 1'b1, 2'd1);
      check(8'd8, 1'b0, "R8 wider period keeps counting");

      // R6: kick at a high count, with a tick in the same cycle
      step(1'b1, 1'b1, 1'b1, 2'd1);
      check(8'd0, 1'b0, "R6 kick wins over tick");

      // R7: disable mid-count, ticks ignored
      for (int n = 0; n < 5; n++) step(1'b1, 1'b0, 1'b1, 2'd0);
      check(8'd5, 1'b0, "R2 count 5 before disable");
      for (int n = 0; n < 12; n++) step(1'b1, 1'b0, 1'b0, 2'd0);
      check(8'd0, 1'b0, "R7 disabled holds zero, no request");
      step(1'b1, 1'b0, 1'b1, 2'd0);
      check(8'd1, 1'b0, "R7 re-enabled counts from zero");

      // R1: power-on reset mid-count
      for (int n = 0; n < 3; n++) step(1'b1, 1'b0, 1'b1, 2'd0);
      check(8'd4, 1'b0, "R2 count 4 before power-on reset");
      por_n = 1'b0;
      @(negedge clk);
      check(8'd0, 1'b0, "R1 power-on reset clears count");
      por_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 2'd0);
      check(8'd0, 1'b0, "R1 count zero after reset release");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run hung, count=%0d expected completion", count_dbg);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule